// File: doc/BRIEF.md
# Remote Terminal Word Receiver

This block is the receive side of a remote terminal on a command/response serial bus. It runs on a clock already recovered from the line, one tick for each half bit. All of its state changes on the falling edge of that clock, so a recovered clock that lags the data by a fraction of a half bit still samples each half cleanly. The line reaches the block as a pair of receiver outputs. When both are low the bus is quiet. When exactly one is high, the high one gives the half-bit level.

Each word has a three-bit-time sync, 16 payload bits and one parity bit. The sync polarity marks the word as a command or a data word. A command sent to this terminal's address opens a message. The command's word-count field gives the number of data words that follow. These data words are written, in order, into a register bank that a downstream serial forwarder reads through a read port. After the last of them, the block pulses a forwarding enable and sends a status word back on a transmit pair. A message error is raised in that status word if any data word in the message had bad parity or broken Manchester coding.

Top module: `rt_word_receiver`

## Requirements
- R1: Each half bit is read from `rx_hi` and is valid only when `rx_hi` differs from `rx_lo`. Six valid halves reading high,high,high,low,low,low form a command sync. Six reading low,low,low,high,high,high form a data sync. A bit is high-then-low for 1 and low-then-high for 0. The payload goes MSB first, then parity. One cycle after the last half is sampled, `word_valid` pulses for one cycle with `word_data` and `word_cmd` (1 for a command sync).
- R2: Parity is odd over the 16 payload bits plus the parity bit. `word_err` pulses with `word_valid` when parity fails.
- R3: A bit whose two halves are equal, or which contains an invalid half, is a code violation. It also raises `word_err`.
- R4: A command opens a message only if it has no error and its bits 15:11 equal `own_addr`. Any other command produces no message, no forwarding pulse and no status word.
- R5: The number of data words expected is command bits 4:0. A value of 0 means 32 words.
- R6: Inside an open message, data word k (counting from 0) is stored at index k. It can be read combinationally at `rd_data` by setting `rd_addr` to k.
- R7: A data word that arrives while no message is open is not stored and triggers nothing.
- R8: On the cycle the last expected data word is reported, `fwd_en` pulses once.
- R9: The status word starts on the transmit pair in that same cycle, one half per cycle, as 40 halves with a command sync. Its bits 15:11 hold `own_addr` and bit 10 holds the message-error flag. All other payload bits are 0 and the parity is odd. `tx_hi` and `tx_lo` are both low when nothing is being sent.
- R10: A valid command to this terminal that arrives while a message is open restarts the message: the index goes back to 0 and the new count applies.
- R11: After reset, all outputs are low and every stored word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Recovered half-bit clock; the falling edge is active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_hi | input | 1 | Line receiver, positive side |
| rx_lo | input | 1 | Line receiver, negative side |
| own_addr | input | 5 | This terminal's address |
| rd_addr | input | 5 | Read index into the stored data words |
| rd_data | output | 16 | Stored word at `rd_addr` |
| word_valid | output | 1 | One-cycle pulse for each received word |
| word_cmd | output | 1 | The word had a command sync |
| word_err | output | 1 | Parity failure or code violation in the word |
| word_data | output | 16 | Payload of the last received word |
| fwd_en | output | 1 | Pulse: message complete, start forwarding |
| tx_hi | output | 1 | Status transmit, positive side |
| tx_lo | output | 1 | Status transmit, negative side |

## Verification
The hardest state to reach from the ports is the 32-word message from a zero count field. Only with this message does the word index reach the edge of the register bank, and the enable must stay quiet after word 31 and fire only on word 32. A directed case sends a zero-count command and 31 words, checks that nothing has fired, then sends the 32nd. Random messages with a fixed seed vary the count, the payloads and the target address. They also corrupt an occasional word, by flipping its parity or by making one bit's halves equal, so that the error bit in the returned status word is tested both clear and set.

// File: rtl/rt_word_receiver.sv
module rt_word_receiver #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 32
) (
  input  logic                         rclk,
  input  logic                         rst_n,
  input  logic                         rx_hi,
  input  logic                         rx_lo,
  input  logic [ADDR_W-1:0]            own_addr,
  input  logic [$clog2(MAX_WORDS)-1:0] rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         word_valid,
  output logic                         word_cmd,
  output logic                         word_err,
  output logic [DATA_W-1:0]            word_data,
  output logic                         fwd_en,
  output logic                         tx_hi,
  output logic                         tx_lo
);
  localparam int SYNC_W    = 6;
  localparam int HALVES    = 2 * (DATA_W + 1);
  localparam int TX_HALVES = SYNC_W + HALVES;
  localparam int CNT_W     = $clog2(HALVES);
  localparam int TX_CW     = $clog2(TX_HALVES + 1);
  localparam int IDX_W     = $clog2(MAX_WORDS + 1);
  localparam int AW        = $clog2(MAX_WORDS);
  localparam int FILL_W    = DATA_W - ADDR_W - 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HALVES - 1);

  logic [SYNC_W-2:0] win_d, win_v;
  logic              in_word, is_cmd_w, h1, v1, viol;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wsr;
  logic              msg_on, msg_err;
  logic [IDX_W-1:0]  idx, expect_n;
  logic [DATA_W-1:0] mem [MAX_WORDS];
  logic [TX_HALVES-1:0] tx_sr, tx_vec;
  logic [TX_CW-1:0]  tx_cnt;

  wire              act      = rx_hi ^ rx_lo;
  wire [SYNC_W-1:0] nd       = {win_d, rx_hi};
  wire [SYNC_W-1:0] nv       = {win_v, act};
  wire              sync_cmd = (&nv) && (nd == 6'b111000);
  wire              sync_dat = (&nv) && (nd == 6'b000111);
  wire              last     = in_word && (cnt == LAST_CNT);
  wire              w_viol   = viol | ~v1 | ~act | (rx_hi == h1);
  wire              w_err    = w_viol | ~(^{wsr, h1});
  wire [ADDR_W-1:0] c_addr   = wsr[DATA_W-1 -: ADDR_W];
  wire [AW-1:0]     c_cnt    = wsr[AW-1:0];
  wire              cmd_ok   = last && is_cmd_w && !w_err && (c_addr == own_addr);
  wire              dat_take = last && !is_cmd_w && msg_on;
  wire [IDX_W-1:0]  idx_n    = idx + 1'b1;
  wire              msg_end  = dat_take && (idx_n == expect_n);
  wire              err_n    = msg_err | w_err;
  wire [DATA_W-1:0] stat_pl  = {own_addr, err_n, {FILL_W{1'b0}}};
  wire [DATA_W:0]   stat_w   = {stat_pl, ~(^stat_pl)};

  always_comb begin
    tx_vec = '0;
    tx_vec[TX_HALVES-1 -: SYNC_W] = 6'b111000;
    for (int i = 0; i <= DATA_W; i++) begin
      tx_vec[TX_HALVES-SYNC_W-1-2*i] = stat_w[DATA_W-i];
      tx_vec[TX_HALVES-SYNC_W-2-2*i] = ~stat_w[DATA_W-i];
    end
  end

  assign rd_data = mem[rd_addr];
  assign tx_hi   = (tx_cnt != '0) &  tx_sr[TX_HALVES-1];
  assign tx_lo   = (tx_cnt != '0) & ~tx_sr[TX_HALVES-1];

  always_ff @(negedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      win_d <= '0; win_v <= '0; in_word <= 1'b0; is_cmd_w <= 1'b0;
      h1 <= 1'b0; v1 <= 1'b0; viol <= 1'b0; cnt <= '0; wsr <= '0;
      word_valid <= 1'b0; word_cmd <= 1'b0; word_err <= 1'b0; word_data <= '0;
    end else begin
      word_valid <= last;
      word_err   <= last && w_err;
      if (last) begin
        word_data <= wsr;
        word_cmd  <= is_cmd_w;
      end
      if (!in_word) begin
        if (sync_cmd || sync_dat) begin
          in_word  <= 1'b1;
          is_cmd_w <= sync_cmd;
          cnt      <= '0;
          viol     <= 1'b0;
          win_d    <= '0;
          win_v    <= '0;
        end else begin
          win_d <= nd[SYNC_W-2:0];
          win_v <= nv[SYNC_W-2:0];
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (!cnt[0]) begin
          h1 <= rx_hi;
          v1 <= act;
        end else begin
          wsr  <= {wsr[DATA_W-2:0], h1};
          viol <= w_viol;
        end
        if (last) in_word <= 1'b0;
      end
    end
  end

  always_ff @(negedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      msg_on <= 1'b0; msg_err <= 1'b0; idx <= '0; expect_n <= '0; fwd_en <= 1'b0;
      tx_sr <= '0; tx_cnt <= '0;
      for (int i = 0; i < MAX_WORDS; i++) mem[i] <= '0;
    end else begin
      fwd_en <= msg_end;
      if (cmd_ok) begin
        msg_on   <= 1'b1;
        msg_err  <= 1'b0;
        idx      <= '0;
        expect_n <= (c_cnt == '0) ? IDX_W'(MAX_WORDS) : IDX_W'(c_cnt);
      end else if (dat_take) begin
        mem[idx[AW-1:0]] <= wsr;
        idx     <= idx_n;
        msg_err <= err_n;
        if (msg_end) msg_on <= 1'b0;
      end
      if (msg_end) begin
        tx_sr  <= tx_vec;
        tx_cnt <= TX_CW'(TX_HALVES);
      end else if (tx_cnt != '0) begin
        tx_sr  <= tx_sr << 1;
        tx_cnt <= tx_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rt_word_receiver_chk.sv
module rt_word_receiver_chk (
  input logic rclk,
  input logic rst_n,
  input logic word_valid,
  input logic word_cmd,
  input logic word_err,
  input logic fwd_en,
  input logic tx_hi,
  input logic tx_lo
);
  AST_WORD_PULSE:   assert property (@(negedge rclk) disable iff (!rst_n) word_valid |=> !word_valid);           // R1
  AST_ERR_IN_WORD:  assert property (@(negedge rclk) disable iff (!rst_n) word_err |-> word_valid);              // R2
  AST_CMD_NO_FWD:   assert property (@(negedge rclk) disable iff (!rst_n) (word_valid && word_cmd) |-> !fwd_en); // R4
  AST_FWD_ON_DATA:  assert property (@(negedge rclk) disable iff (!rst_n) fwd_en |-> (word_valid && !word_cmd)); // R8
  AST_FWD_PULSE:    assert property (@(negedge rclk) disable iff (!rst_n) fwd_en |=> !fwd_en);                   // R8
  AST_STATUS_SYNC:  assert property (@(negedge rclk) disable iff (!rst_n) fwd_en |-> (tx_hi && !tx_lo));         // R9
  AST_TX_EXCL:      assert property (@(negedge rclk) disable iff (!rst_n) !(tx_hi && tx_lo));                    // R9
endmodule

bind rt_word_receiver rt_word_receiver_chk u_chk (
  .rclk(rclk), .rst_n(rst_n), .word_valid(word_valid), .word_cmd(word_cmd),
  .word_err(word_err), .fwd_en(fwd_en), .tx_hi(tx_hi), .tx_lo(tx_lo)
);

// File: tb/rt_word_receiver_tb.sv
module rt_word_receiver_tb;
  localparam logic [4:0] OWN = 5'd19;

  logic clk = 1'b0, rst_n = 1'b0, rx_hi = 1'b0, rx_lo = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data, word_data;
  logic word_valid, word_cmd, word_err, fwd_en, tx_hi, tx_lo;

  rt_word_receiver u_dut (
    .rclk(clk), .rst_n(rst_n), .rx_hi(rx_hi), .rx_lo(rx_lo), .own_addr(OWN),
    .rd_addr(rd_addr), .rd_data(rd_data), .word_valid(word_valid), .word_cmd(word_cmd),
    .word_err(word_err), .word_data(word_data), .fwd_en(fwd_en), .tx_hi(tx_hi), .tx_lo(tx_lo)
  );

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  int ev_n = 0, fwd_n = 0, st_n = 0;
  logic [15:0] ev_d [64];
  logic        ev_c [64];
  logic        ev_e [64];
  logic [39:0] st_v = '0;
  logic [15:0] dat [32];
  int          flt [32];

  always @(posedge clk) begin
    if (word_valid) begin
      ev_d[ev_n & 63] = word_data; ev_c[ev_n & 63] = word_cmd; ev_e[ev_n & 63] = word_err;
      ev_n++;
    end
    if (fwd_en) fwd_n++;
    if (tx_hi || tx_lo) begin
      st_v = {st_v[38:0], tx_hi};
      st_n++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] enc(input bit cmd, input logic [15:0] d, input int fault);
    logic [39:0] h;
    logic p, b;
    p = ~(^d);
    if (fault == 1) p = ~p;
    h[39:34] = cmd ? 6'b111000 : 6'b000111;
    for (int i = 0; i <= 16; i++) begin
      b = (i < 16) ? d[15-i] : p;
      h[33-2*i] = b;
      h[32-2*i] = ~b;
    end
    if (fault == 2) h[22] = h[23];
    return h;
  endfunction

  task automatic send(input bit cmd, input logic [15:0] d, input int fault);
    logic [39:0] h;
    h = enc(cmd, d, fault);
    for (int k = 39; k >= 0; k--) begin
      @(posedge clk); #2;
      rx_hi = h[k]; rx_lo = ~h[k];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      rx_hi = 1'b0; rx_lo = 1'b0;
    end
  endtask

  task automatic clr();
    @(posedge clk); #2;
    ev_n = 0; fwd_n = 0; st_n = 0;
  endtask

  task automatic do_msg(input logic [4:0] to, input logic [4:0] wc, input int n);
    int  need;
    bit  done, err;
    logic [15:0] cw;
    clr();
    cw = {to, 1'b0, 5'd1, wc};
    need = (wc == 0) ? 32 : int'(wc);
    done = (to == OWN) && (n >= need);
    err = 1'b0;
    send(1'b1, cw, 0);
    for (int i = 0; i < n; i++) begin
      send(1'b0, dat[i], flt[i]);
      if (flt[i] != 0) err = 1'b1;
    end
    idle(50);
    chk("R1 word count", 64'(ev_n), 64'(n + 1));
    chk("R1 command flag", 64'(ev_c[0]), 64'd1);
    chk("R1 command payload", 64'(ev_d[0]), 64'(cw));
    for (int i = 0; i < n && i < 63; i++) begin
      chk("R1 data flag", 64'(ev_c[i+1]), 64'd0);
      chk(flt[i] == 1 ? "R2 parity error flag" : (flt[i] == 2 ? "R3 code violation flag" : "R2 clean word flag"),
          64'(ev_e[i+1]), 64'(flt[i] != 0));
      if (flt[i] == 0) chk("R1 data payload", 64'(ev_d[i+1]), 64'(dat[i]));
    end
    chk(to == OWN ? "R8 forward pulse count" : "R4 foreign address no pulse", 64'(fwd_n), 64'(done));
    chk("R9 status length", 64'(st_n), done ? 64'd40 : 64'd0);
    if (done) begin
      chk("R9 status word", 64'(st_v), 64'(enc(1'b1, {OWN, err, 10'b0}, 0)));
      for (int i = 0; i < need; i++) begin
        if (flt[i] == 0) begin
          rd_addr = 5'(i); #1;
          chk("R6 stored word", 64'(rd_data), 64'(dat[i]));
        end
      end
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) begin dat[i] = '0; flt[i] = 0; end
    #1;
    chk("R11 reset word_valid", 64'(word_valid), 64'd0);
    chk("R11 reset fwd_en", 64'(fwd_en), 64'd0);
    chk("R11 reset tx idle", 64'({tx_hi, tx_lo}), 64'd0);
    #30; rst_n = 1'b1;
    idle(10);
    chk("R11 reset storage", 64'(rd_data), 64'd0);

    clr();
    send(1'b0, 16'hBEEF, 0);
    send(1'b0, 16'h1234, 0);
    idle(50);
    chk("R7 stray data no pulse", 64'(fwd_n), 64'd0);
    chk("R7 stray data no status", 64'(st_n), 64'd0);
    rd_addr = 5'd0; #1; chk("R7 stray data not stored", 64'(rd_data), 64'd0);
    rd_addr = 5'd1; #1; chk("R7 stray data not stored", 64'(rd_data), 64'd0);

    dat[0] = 16'h4142; dat[1] = 16'h0000; dat[2] = 16'hFFFF;
    do_msg(OWN, 5'd3, 3);
    do_msg(OWN ^ 5'd1, 5'd2, 2);

    clr();
    send(1'b1, {OWN, 1'b0, 5'd1, 5'd1}, 1);
    send(1'b0, 16'h5555, 0);
    idle(50);
    chk("R4 bad parity command ignored", 64'(fwd_n), 64'd0);

    dat[0] = 16'h0F0F; flt[0] = 2; dat[1] = 16'h7777;
    do_msg(OWN, 5'd2, 2);
    flt[0] = 0;

    clr();
    send(1'b1, {OWN, 1'b0, 5'd1, 5'd4}, 0);
    send(1'b0, 16'hDEAD, 0);
    send(1'b0, 16'hCAFE, 0);
    dat[0] = 16'h1111; dat[1] = 16'h2222;
    do_msg(OWN, 5'd2, 2);
    chk("R10 restart forward once", 64'(fwd_n), 64'd1);

    for (int i = 0; i < 32; i++) begin dat[i] = 16'($urandom); flt[i] = 0; end
    do_msg(OWN, 5'd0, 31);
    chk("R5 count zero not done at 31", 64'(fwd_n), 64'd0);
    clr();
    dat[31] = 16'h8001;
    send(1'b0, dat[31], 0);
    idle(50);
    chk("R5 count zero done at 32", 64'(fwd_n), 64'd1);
    chk("R9 status after 32", 64'(st_v), 64'(enc(1'b1, {OWN, 1'b0, 10'b0}, 0)));
    rd_addr = 5'd31; #1; chk("R6 last slot", 64'(rd_data), 64'(dat[31]));

    for (int m = 0; m < 20; m++) begin
      int n;
      logic [4:0] to;
      n = 1 + int'($urandom % 8);
      to = ($urandom % 5 == 0) ? 5'($urandom) : OWN;
      for (int i = 0; i < n; i++) begin
        dat[i] = 16'($urandom);
        flt[i] = ($urandom % 6 == 0) ? 1 + int'($urandom % 2) : 0;
      end
      do_msg(to, 5'(n), n);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule